// File: doc/BRIEF.md
# Loopback and Transmit Timing Source Controller

This block sits between a framer and a line interface and decides, every clock cycle, where transmit and receive data flow and which timing strobe paces the transmitter. In normal operation framer words go to the line and line words go to the receiver. A remote loop sends the received line words back out to the line in place of the framer's words; a local loop feeds the transmitter's output straight into the receiver in place of the line.

Clocks are modelled as single-cycle enables on one system clock: a reference strobe and a recovered-receive strobe. In hub mode the transmitter follows the reference strobe; in host mode, and whenever the remote loop is active, it follows the recovered strobe. When the line signal is lost while the recovered strobe would be chosen, the transmitter falls back to the reference strobe and a status output reports the fallback. All four control inputs pass through a synchronizer, and a loop change is applied only at the boundary of a transmit word, counted in transmit strobes, so no word is cut short.

Top module: `lbk_timing_loop_ctrl`

## Requirements
- R1: While `rst` is high, the route is normal (`line_tx_data` equals `host_tx_data`, `rx_in_data` equals `line_rx_data`), `host_rx_data` is zero and `timing_fallback` is low; the word-tick counter restarts at zero.
- R2: With the remote loop applied, `line_tx_data` equals `line_rx_data`.
- R3: With the local loop applied, `rx_in_data` equals `line_tx_data`, which is then `host_tx_data`.
- R4: A remote loop request overrides a local loop request: with both requested, the remote loop is applied and `rx_in_data` follows `line_rx_data`.
- R5: A local loop request has no effect while `hub_mode` is low.
- R6: With `hub_mode` high and no remote loop request, `tx_tick` equals `ref_tick`.
- R7: With `hub_mode` low and no loss of signal, `tx_tick` equals `rec_tick`.
- R8: With a remote loop request and no loss of signal, `tx_tick` equals `rec_tick` whatever `hub_mode` is.
- R9: Each control input acts on the outputs two clock cycles after it is sampled: a change driven before edge k is seen at the outputs after edge k+1.
- R10: The applied route changes only at the edge where `tx_tick` is high and WORD_TICKS (default 4) transmit ticks have been counted since reset or the last boundary; it then takes the route requested by the synchronized controls.
- R11: When the recovered strobe would be chosen (host mode or remote loop requested) and synchronized `los` is high, `tx_tick` equals `ref_tick` and `timing_fallback` is high; otherwise `timing_fallback` is low.
- R12: `host_rx_data` equals `rx_in_data` delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tx_data | input | DATA_W | Transmit word from the framer |
| line_rx_data | input | DATA_W | Received word from the line |
| ref_tick | input | 1 | Reference timing strobe |
| rec_tick | input | 1 | Recovered receive timing strobe |
| local_loop | input | 1 | Request to feed the transmitter output into the receiver |
| remote_loop | input | 1 | Request to return received words to the line |
| hub_mode | input | 1 | High: reference timing; low: recovered timing |
| los | input | 1 | Loss of signal from the analog detector |
| line_tx_data | output | DATA_W | Word sent to the line |
| rx_in_data | output | DATA_W | Word presented to the receiver |
| host_rx_data | output | DATA_W | Received word delivered to the framer |
| tx_tick | output | 1 | Selected transmit timing strobe |
| timing_fallback | output | 1 | High while loss of signal forces reference timing |

## Verification
On every cycle the assertions check that the applied route holds between word boundaries, that a local loop only ever becomes active from a hub-mode request with no remote request, that the strobe choice matches the synchronized hub, remote and loss-of-signal state, and that the receive word lags the receiver input by one cycle. Only the bench's scenarios can show the two-cycle synchronizer delay seen at the pins, the exact boundary edge counted in strobes from reset, and the full data routing under mixed and rapidly changing requests, which it tracks against a behavioural model compared every cycle.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef enum logic [1:0] {
        ROUTE_NORMAL = 2'd0,
        ROUTE_LOCAL  = 2'd1,
        ROUTE_REMOTE = 2'd2
    } route_t;

    typedef struct packed {
        logic llb;
        logic rlb;
        logic hub;
        logic los;
    } ctl_t;

    // Remote loop dominates; local loop needs hub mode.
    function automatic route_t pick_route(input ctl_t c);
        if (c.rlb)
            return ROUTE_REMOTE;
        else if (c.llb && c.hub)
            return ROUTE_LOCAL;
        else
            return ROUTE_NORMAL;
    endfunction

    function automatic logic wants_recovered(input ctl_t c);
        return c.rlb | ~c.hub;
    endfunction

endpackage

// File: rtl/lbk_ctl_sync.sv
module lbk_ctl_sync
    import lbk_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t raw,
    output ctl_t synced
);
    ctl_t stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign synced = stg[STAGES-1];
endmodule

// File: rtl/lbk_tick_sel.sv
module lbk_tick_sel
    import lbk_pkg::*;
#(
    parameter int WORD_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic ref_tick,
    input  logic rec_tick,
    output logic tx_tick,
    output logic fallback,
    output logic boundary
);
    localparam int CW = (WORD_TICKS > 1) ? $clog2(WORD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_TICKS - 1);

    logic          want_rec;
    logic [CW-1:0] tick_cnt;

    always_comb begin
        want_rec = wants_recovered(ctl);
        fallback = want_rec & ctl.los;
        tx_tick  = (want_rec && !ctl.los) ? rec_tick : ref_tick;
        boundary = tx_tick && (tick_cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)
            tick_cnt <= '0;
        else if (tx_tick)
            tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
    end

    assert_cnt_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        tick_cnt <= LAST);

    assert_cnt_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !tx_tick |=> $stable(tick_cnt));
endmodule

// File: rtl/lbk_route.sv
module lbk_route
    import lbk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  route_t            req,
    input  logic              boundary,
    input  logic [DATA_W-1:0] host_tx,
    input  logic [DATA_W-1:0] line_rx,
    output logic [DATA_W-1:0] line_tx,
    output logic [DATA_W-1:0] rx_in,
    output logic [DATA_W-1:0] host_rx,
    output route_t            mode
);
    always_ff @(posedge clk) begin
        if (rst)           mode <= ROUTE_NORMAL;
        else if (boundary) mode <= req;
    end

    always_comb begin
        line_tx = (mode == ROUTE_REMOTE) ? line_rx : host_tx;
        rx_in   = (mode == ROUTE_LOCAL)  ? line_tx : line_rx;
    end

    always_ff @(posedge clk) begin
        if (rst) host_rx <= '0;
        else     host_rx <= rx_in;
    end

    assert_route_only_at_boundary_R10: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(mode));

    assert_never_both_loops_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == ROUTE_LOCAL) |-> (line_tx == host_tx));
endmodule

// File: rtl/lbk_timing_loop_ctrl.sv
module lbk_timing_loop_ctrl
    import lbk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int WORD_TICKS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic [DATA_W-1:0] line_rx_data,
    input  logic              ref_tick,
    input  logic              rec_tick,
    input  logic              local_loop,
    input  logic              remote_loop,
    input  logic              hub_mode,
    input  logic              los,
    output logic [DATA_W-1:0] line_tx_data,
    output logic [DATA_W-1:0] rx_in_data,
    output logic [DATA_W-1:0] host_rx_data,
    output logic              tx_tick,
    output logic              timing_fallback
);
    ctl_t   ctl_raw;
    ctl_t   ctl_s;
    logic   boundary;
    route_t mode;

    assign ctl_raw = '{llb: local_loop, rlb: remote_loop, hub: hub_mode, los: los};

    lbk_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (ctl_raw),
        .synced (ctl_s)
    );

    lbk_tick_sel #(.WORD_TICKS(WORD_TICKS)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl_s),
        .ref_tick (ref_tick),
        .rec_tick (rec_tick),
        .tx_tick  (tx_tick),
        .fallback (timing_fallback),
        .boundary (boundary)
    );

    lbk_route #(.DATA_W(DATA_W)) u_route (
        .clk      (clk),
        .rst      (rst),
        .req      (pick_route(ctl_s)),
        .boundary (boundary),
        .host_tx  (host_tx_data),
        .line_rx  (line_rx_data),
        .line_tx  (line_tx_data),
        .rx_in    (rx_in_data),
        .host_rx  (host_rx_data),
        .mode     (mode)
    );

    assert_local_needs_hub_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mode == ROUTE_LOCAL) |-> $past(ctl_s.hub && !ctl_s.rlb && ctl_s.llb));

    assert_hub_uses_ref_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.hub && !ctl_s.rlb) |-> (tx_tick == ref_tick));

    assert_remote_uses_rec_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.rlb && !ctl_s.los) |-> (tx_tick == rec_tick));

    assert_host_los_fallback_R11: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.los && !ctl_s.hub) |-> (timing_fallback && tx_tick == ref_tick));

    assert_rx_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (host_rx_data == $past(rx_in_data)));
endmodule

// File: tb/test_lbk_timing_loop_ctrl.sv
`timescale 1ns/1ps
module test_lbk_timing_loop_ctrl;
    localparam int W  = 8;
    localparam int WT = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] host_tx_data = '0, line_rx_data = '0;
    logic         ref_tick = 0, rec_tick = 0;
    logic         local_loop = 0, remote_loop = 0, hub_mode = 0, los = 0;
    logic [W-1:0] line_tx_data, rx_in_data, host_rx_data;
    logic         tx_tick, timing_fallback;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lbk_timing_loop_ctrl #(.DATA_W(W), .WORD_TICKS(WT), .SYNC_STAGES(2)) i_lbk_timing_loop_ctrl (
        .clk, .rst, .host_tx_data, .line_rx_data, .ref_tick, .rec_tick,
        .local_loop, .remote_loop, .hub_mode, .los,
        .line_tx_data, .rx_in_data, .host_rx_data, .tx_tick, .timing_fallback
    );

    // Behavioural model: controls delayed through a two-entry queue,
    // route 0 normal / 1 local / 2 remote.
    bit [3:0]     ctl_q[$];   // {llb, rlb, hub, los}
    int           m_cnt, m_mode;
    logic [W-1:0] m_rx;

    function automatic bit m_want_rec(bit [3:0] c); return c[2] || !c[1]; endfunction
    function automatic bit m_tick(bit [3:0] c);
        return (m_want_rec(c) && !c[0]) ? rec_tick : ref_tick;
    endfunction
    function automatic logic [W-1:0] m_line_tx();
        return (m_mode == 2) ? line_rx_data : host_tx_data;
    endfunction
    function automatic logic [W-1:0] m_rx_in();
        return (m_mode == 1) ? m_line_tx() : line_rx_data;
    endfunction

    initial begin
        ctl_q = '{4'b0, 4'b0};
        m_cnt = 0; m_mode = 0; m_rx = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            ctl_q = '{4'b0, 4'b0};
            m_cnt = 0; m_mode = 0; m_rx = '0;
        end else begin
            bit [3:0] c;
            c = ctl_q[0];
            m_rx = m_rx_in();
            if (m_tick(c)) begin
                if (m_cnt == WT - 1) begin
                    m_cnt = 0;
                    m_mode = c[2] ? 2 : ((c[3] && c[1]) ? 1 : 0);
                end else m_cnt++;
            end
            ctl_q.push_back({local_loop, remote_loop, hub_mode, los});
            void'(ctl_q.pop_front());
        end
    end

    task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare_model();
        bit [3:0] c;
        string ttag;
        c = ctl_q[0];
        ttag = c[2] ? "R8" : (c[1] ? "R6" : "R7");
        if (c[0] && m_want_rec(c)) ttag = "R11";
        check(m_mode == 2 ? "R2" : "R10", "line_tx_data", line_tx_data, m_line_tx());
        check(m_mode == 1 ? "R3" : "R10", "rx_in_data", rx_in_data, m_rx_in());
        check("R12", "host_rx_data", host_rx_data, m_rx);
        check(ttag, "tx_tick", W'(tx_tick), W'(m_tick(c)));
        check("R11", "timing_fallback", W'(timing_fallback), W'(m_want_rec(c) && c[0]));
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic cyc(bit t_ref, bit t_rec);
        @(negedge clk);
        compare_model();
        host_tx_data = W'($urandom);
        line_rx_data = W'($urandom);
        ref_tick = t_ref;
        rec_tick = t_rec;
    endtask

    task automatic set_ctl(bit l, bit r, bit h, bit s);
        local_loop = l; remote_loop = r; hub_mode = h; los = s;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        set_ctl(0, 0, 0, 0);
        repeat (3) cyc(0, 0);
        #1;
        // R1: reset values at the pins
        check("R1", "reset host_rx_data", host_rx_data, '0);
        check("R1", "reset timing_fallback", W'(timing_fallback), '0);
        check("R1", "reset line_tx_data", line_tx_data, host_tx_data);
        check("R1", "reset rx_in_data", rx_in_data, line_rx_data);
        rst = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        do_reset();

        // R10 and R2: remote request, boundary on the fourth recovered tick
        set_ctl(0, 1, 1, 0);
        repeat (4) cyc(0, 0);
        repeat (3) cyc(0, 1);
        cyc(0, 0);
        #1 check("R10", "no route change before boundary", line_tx_data, host_tx_data);
        cyc(0, 1);
        cyc(0, 0);
        #1 check("R2", "remote loop active", line_tx_data, line_rx_data);

        // R9: hub rises with remote off; ref selected two edges later
        set_ctl(0, 0, 0, 0);
        repeat (4) cyc(0, 0);
        set_ctl(0, 0, 1, 0);
        cyc(1, 0);
        #1 check("R9", "tick after one edge", W'(tx_tick), W'(0));
        cyc(1, 0);
        #1 check("R9", "tick after two edges", W'(tx_tick), W'(1));

        // R4: both loops requested, remote wins
        set_ctl(1, 1, 1, 0);
        repeat (12) cyc(1, 1);
        #1 check("R4", "receiver not looped", rx_in_data, line_rx_data);

        // R5: local request in host mode is ignored
        do_reset();
        set_ctl(1, 0, 0, 0);
        repeat (12) cyc(1, 1);
        #1 check("R5", "receiver not looped", rx_in_data, line_rx_data);

        // R3: local loop in hub mode
        set_ctl(1, 0, 1, 0);
        repeat (12) cyc(1, 0);
        #1 check("R3", "receiver looped", rx_in_data, host_tx_data);

        // R7, R8, R11 and mixed traffic under the model
        for (int blk = 0; blk < 80; blk++) begin
            set_ctl($urandom_range(0, 1), ($urandom_range(0, 3) == 0),
                    $urandom_range(0, 1), ($urandom_range(0, 4) == 0));
            for (int k = 0; k < 30; k++)
                cyc($urandom_range(0, 1), $urandom_range(0, 1));
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule